// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block collects the event signals of an I2C bus master (packet completion, FIFO faults, bus errors and FIFO data requests) into one sticky status register. Each source owns one bit, and a bit stays set until software writes a one to it. A second register enables sources one by one. The block drives a single level interrupt line from the enabled status bits, one clock after they change.

Software reaches both registers through one word-wide port. A one-bit register select chooses between them. Reads have no side effects and return the register contents as they are. An elaboration option lets the packet-complete source raise the interrupt whatever its enable bit holds. A driver that always waits for that event then needs no mask update.

Top module: `irq_status_unit`

## Requirements
- R1: Event input bit n sets status bit n on the next clock. The bit layout is: 7 packet done, 6 all packets done, 5 transmit overflow, 4 receive underflow, 3 missing acknowledge, 2 arbitration lost, 1 transmit data request, 0 receive data request.
- R2: A set status bit keeps its value until it is cleared by a write, even after its event input returns low.
- R3: A write with sel=0 clears every status bit whose write-data bit is 1 and leaves the other bits unchanged. Writing back a value just read clears exactly the bits that were set.
- R4: When an event and a clearing write reach the same status bit in the same cycle, the bit stays set.
- R5: A write with sel=1 loads the mask register. The mask and the status both reset to all zeros.
- R6: irq_o is a registered copy of the OR over all bits of status ANDed with the effective mask, so it changes one clock after the status or mask does. A mask bit of 1 enables its source.
- R7: With PKT_ALWAYS_EN=1 (the default), status bit 7 drives irq_o even when mask bit 7 is 0. The mask register still reads back the value that was written to it.
- R8: Reading with sel=0 returns the raw status, whatever the mask holds. Reading with sel=1 returns the mask.
- R9: A data-request input (bit 0 or bit 1) that is held high sets its status bit again in every cycle. A clear therefore has no lasting effect while the input stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_i | input | 8 | Event inputs, one per status bit |
| sel_i | input | 1 | Register select: 0 status, 1 mask |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data of the selected register |
| irq_o | output | 1 | Level interrupt line |

## Verification
The sticky update can see an event and a software clear on the same bit in the same cycle. The bench provokes this by pulsing an event while it writes a one to that bit. It also holds a data-request input high across a clear. Its reference model applies the clear first and the event second, and compares the status read-back and the interrupt line on every clock. The model thereby decides the same-cycle case independently of the RTL.

// File: rtl/irq_pkg.sv
package irq_pkg;
   typedef enum logic {
      SEL_STATUS = 1'b0,
      SEL_MASK   = 1'b1
   } reg_sel_e;

   localparam int unsigned SRC_RX_REQ    = 0;
   localparam int unsigned SRC_TX_REQ    = 1;
   localparam int unsigned SRC_ARB_LOST  = 2;
   localparam int unsigned SRC_NO_ACK    = 3;
   localparam int unsigned SRC_RX_UNDER  = 4;
   localparam int unsigned SRC_TX_OVER   = 5;
   localparam int unsigned SRC_ALL_DONE  = 6;
   localparam int unsigned SRC_PKT_DONE  = 7;
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] ev_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] status_o
);
   for (genvar b = 0; b < W; b++) begin : g_bit
      logic flag_q;
      always_ff @(posedge clk) begin
         if (!rst_n)          flag_q <= 1'b0;
         else if (ev_i[b])    flag_q <= 1'b1;
         else if (clr_i[b])   flag_q <= 1'b0;
      end
      assign status_o[b] = flag_q;
   end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
   parameter int unsigned W         = 8,
   parameter int unsigned FORCE_BIT = 7,
   parameter bit          FORCE_EN  = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] mask_o,
   output logic [W-1:0] eff_o
);
   logic [W-1:0] mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    mask_q <= '0;
      else if (we_i) mask_q <= wdata_i;
   end

   assign mask_o = mask_q;

   if (FORCE_EN) begin : g_forced
      localparam logic [W-1:0] FORCE_VEC = W'(1) << FORCE_BIT;
      assign eff_o = mask_q | FORCE_VEC;
   end else begin : g_plain
      assign eff_o = mask_q;
   end
endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] status_i,
   input  logic [W-1:0] enable_i,
   output logic         irq_o
);
   logic irq_q;
   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(status_i & enable_i);
   end
   assign irq_o = irq_q;
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
   import irq_pkg::*;
#(
   parameter int unsigned NSRC          = 8,
   parameter int unsigned PKT_BIT       = SRC_PKT_DONE,
   parameter bit          PKT_ALWAYS_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] ev_i,
   input  logic            sel_i,
   input  logic            wr_en_i,
   input  logic [NSRC-1:0] wr_data_i,
   output logic [NSRC-1:0] rd_data_o,
   output logic            irq_o
);
   if (PKT_BIT >= NSRC) begin : g_bad_pkt_bit
      $error("PKT_BIT must index a source below NSRC");
   end
   if (NSRC < 1 || NSRC > 32) begin : g_bad_width
      $error("NSRC must lie between 1 and 32");
   end

   reg_sel_e        sel;
   logic [NSRC-1:0] clr_vec;
   logic            mask_we;
   logic [NSRC-1:0] status_q;
   logic [NSRC-1:0] mask_q;
   logic [NSRC-1:0] eff_mask;

   assign sel     = reg_sel_e'(sel_i);
   assign clr_vec = (wr_en_i && sel == SEL_STATUS) ? wr_data_i : '0;
   assign mask_we = wr_en_i && sel == SEL_MASK;

   irq_sticky_bank #(.W(NSRC)) u_sticky (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_i     (ev_i),
      .clr_i    (clr_vec),
      .status_o (status_q)
   );

   irq_mask_bank #(.W(NSRC), .FORCE_BIT(PKT_BIT), .FORCE_EN(PKT_ALWAYS_EN)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (mask_we),
      .wdata_i (wr_data_i),
      .mask_o  (mask_q),
      .eff_o   (eff_mask)
   );

   irq_line_gen #(.W(NSRC)) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .status_i (status_q),
      .enable_i (eff_mask),
      .irq_o    (irq_o)
   );

   assign rd_data_o = (sel == SEL_MASK) ? mask_q : status_q;
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk #(
   parameter int unsigned NSRC          = 8,
   parameter int unsigned PKT_BIT       = 7,
   parameter bit          PKT_ALWAYS_EN = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic [NSRC-1:0] ev_i,
   input logic            sel_i,
   input logic            wr_en_i,
   input logic [NSRC-1:0] wr_data_i,
   input logic [NSRC-1:0] status_q,
   input logic [NSRC-1:0] mask_q,
   input logic            irq_o
);
   logic [NSRC-1:0] force_vec;
   assign force_vec = PKT_ALWAYS_EN ? (NSRC'(1) << PKT_BIT) : '0;

   // R1 / R4: an event always leaves its bit set next cycle
   p_event_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i != '0) |=> ((status_q & $past(ev_i)) == $past(ev_i)));

   // R3: cleared bits without a same-cycle event drop
   p_clear_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !sel_i) |=> ((status_q & $past(wr_data_i) & ~$past(ev_i)) == '0));

   // R2: no bit falls without a clearing write
   p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_i && !sel_i) |=> (($past(status_q) & ~status_q) == '0));

   // R5: mask changes only on a mask write
   p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_i && sel_i) |=> $stable(mask_q));

   // R6 / R7: interrupt line follows masked status one clock later
   p_irq_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == $past(|(status_q & (mask_q | force_vec))));
endmodule

bind irq_status_unit irq_status_unit_chk #(
   .NSRC(NSRC), .PKT_BIT(PKT_BIT), .PKT_ALWAYS_EN(PKT_ALWAYS_EN)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ev_i      (ev_i),
   .sel_i     (sel_i),
   .wr_en_i   (wr_en_i),
   .wr_data_i (wr_data_i),
   .status_q  (status_q),
   .mask_q    (mask_q),
   .irq_o     (irq_o)
);

// File: tb/sim_irq_status_unit.sv
`timescale 1ns/1ps
module sim_irq_status_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] ev = '0;
   logic       sel = 1'b0;
   logic       wr = 1'b0;
   logic [7:0] wd = '0;
   logic [7:0] rd;
   logic       irq;

   int n_run = 0;
   int n_fail = 0;
   int cyc = 0;
   string cur_req = "R5";
   bit    done = 1'b0;

   // reference model state
   int m_stat = 0;
   int m_mask = 0;
   int m_irq  = 0;

   always #2.5 clk = ~clk;

   irq_status_unit u0 (
      .clk(clk), .rst_n(rst_n), .ev_i(ev), .sel_i(sel), .wr_en_i(wr),
      .wr_data_i(wd), .rd_data_o(rd), .irq_o(irq)
   );

   always @(posedge clk) begin
      int nxt_stat;
      int eff;
      cyc <= cyc + 1;
      if (!rst_n) begin
         m_stat <= 0; m_mask <= 0; m_irq <= 0;
      end else begin
         nxt_stat = m_stat;
         if (wr && !sel) nxt_stat = nxt_stat & ~int'(wd);
         nxt_stat = nxt_stat | int'(ev);
         eff = m_mask | 8'h80;
         m_irq  <= ((m_stat & eff) != 0) ? 1 : 0;
         m_stat <= nxt_stat;
         if (wr && sel) m_mask <= int'(wd);
      end
   end

   task automatic check(string req, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check({cur_req, " read"}, int'(rd), sel ? m_mask : m_stat);
         check({cur_req, " irq (R6)"}, int'(irq), m_irq);
      end
   end

   task automatic step(logic [7:0] e, logic s, logic w, logic [7:0] d);
      @(posedge clk); #1;
      ev = e; sel = s; wr = w; wd = d;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R5: reset values of status, mask, irq
      @(negedge clk);
      check("R5 status reset", int'(rd), 0);
      check("R5 irq reset", int'(irq), 0);
      sel = 1'b1; #0.1;
      check("R5 mask reset", int'(rd), 0);

      // R1: single pulses on each source, status read
      cur_req = "R1";
      for (int b = 0; b < 8; b++) begin
         step(8'(1 << b), 1'b0, 1'b0, 8'h00);
         step(8'h00, 1'b0, 1'b0, 8'h00);
      end
      // R2: bits held with events low
      cur_req = "R2";
      repeat (4) step(8'h00, 1'b0, 1'b0, 8'h00);
      // R3: partial clear then write-back of read value
      cur_req = "R3";
      step(8'h00, 1'b0, 1'b1, 8'h0F);
      step(8'h00, 1'b0, 1'b0, 8'h00);
      step(8'h00, 1'b0, 1'b1, 8'hF0);
      step(8'h00, 1'b0, 1'b0, 8'h00);
      // R7: packet-done raises irq with mask zero
      cur_req = "R7";
      step(8'h80, 1'b0, 1'b0, 8'h00);
      repeat (3) step(8'h00, 1'b0, 1'b0, 8'h00);
      step(8'h00, 1'b1, 1'b0, 8'h00);
      step(8'h00, 1'b0, 1'b1, 8'h80);
      step(8'h00, 1'b0, 1'b0, 8'h00);
      step(8'h00, 1'b0, 1'b0, 8'h00);
      // R8: status raw while mask zero, unmasked sources give no irq
      cur_req = "R8";
      step(8'h24, 1'b0, 1'b0, 8'h00);
      repeat (3) step(8'h00, 1'b0, 1'b0, 8'h00);
      // R5 / R6: enable bit 2 then bit 5 only
      cur_req = "R5";
      step(8'h00, 1'b1, 1'b1, 8'h04);
      step(8'h00, 1'b1, 1'b0, 8'h00);
      cur_req = "R6";
      step(8'h00, 1'b0, 1'b0, 8'h00);
      step(8'h00, 1'b0, 1'b1, 8'h04);
      step(8'h00, 1'b0, 1'b0, 8'h00);
      step(8'h00, 1'b0, 1'b0, 8'h00);
      step(8'h00, 1'b1, 1'b1, 8'h20);
      step(8'h00, 1'b0, 1'b0, 8'h00);
      step(8'h00, 1'b0, 1'b1, 8'h20);
      step(8'h00, 1'b0, 1'b0, 8'h00);
      // R4: event and clear on the same bit, same cycle
      cur_req = "R4";
      step(8'h08, 1'b0, 1'b0, 8'h00);
      step(8'h08, 1'b0, 1'b1, 8'h08);
      step(8'h00, 1'b0, 1'b0, 8'h00);
      step(8'h00, 1'b0, 1'b1, 8'h08);
      step(8'h00, 1'b0, 1'b0, 8'h00);
      // R9: data-request held high across clears
      cur_req = "R9";
      step(8'h03, 1'b1, 1'b1, 8'h03);
      step(8'h03, 1'b0, 1'b1, 8'h03);
      step(8'h03, 1'b0, 1'b1, 8'h03);
      step(8'h03, 1'b0, 1'b0, 8'h00);
      step(8'h00, 1'b0, 1'b1, 8'h03);
      step(8'h00, 1'b0, 1'b0, 8'h00);
      step(8'h00, 1'b1, 1'b0, 8'h00);
      step(8'h00, 1'b0, 1'b0, 8'h00);
      @(negedge clk); #0.5;
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      wait (cyc > 200000);
      if (!done) begin
         done = 1'b1;
         n_run++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=<200000", cyc);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule